// File: doc/BRIEF.md
# Progressive-to-Interlaced Field Converter

This block sits in a packetized video pipeline and turns each progressive frame into one interlaced field. It keeps either the even lines (an F0 field) or the odd lines (an F1 field) of each frame, so the output field rate matches the input frame rate. The outgoing control packet is rewritten to describe the field. Frames that are already interlaced are either forwarded unchanged or removed completely. Hints in the interlace nibble can force the parity of a progressive frame that was produced from interlaced material. The F0/F1 sequence restarts on a resolution change or on request from software.

Both stream sides use a valid/ready handshake with start-of-packet and end-of-packet flags, one word per beat. The low nibble of a packet's first word gives its type: 0xF marks a control packet and 0x0 marks a video packet. A control packet has four beats: type word, width, height, and a word whose low nibble is the interlace nibble. Nibble bit 3 set means the frame is interlaced, with bit 0 giving its field. A video packet is a type word followed by the pixels in row-major order, one pixel per beat.

Each video packet follows its control packet, and heights are at least 2. A video packet that arrives without a control packet is discarded. A single run-time control word sets the behaviour, and every field of it is sampled when a control packet header is accepted.

Top module: `p2f_interlacer`

## Requirements
- R1: An F0 field carries only rows 0, 2, 4, ... of the frame and an F1 field carries only rows 1, 3, 5, ... (row 0 is first). Pixels are unchanged and in order. The video type word is forwarded with sop, and eop marks the last pixel that is kept.
- R2: Each progressive frame that is interlaced yields exactly one field. Without a restart or a hint, the parity alternates F0, F1, F0, and so on. Interlaced or passed-through frames in between do not advance the sequence.
- R3: The rewritten control packet is type 0xF, the same width, a height of ceil(h/2) for F0 or floor(h/2) for F1, and a nibble word of 0x0008 for F0 or 0x0009 for F1.
- R4: Control bit 2 selects the starting field (0 = F0, 1 = F1). This field is used for the first interlaced frame after reset and after any restart.
- R5: A frame whose nibble has bit 3 set goes through unchanged (control and video packets) when control bit 1 is 1. When control bit 1 is 0, both of its packets are discarded and produce no output.
- R6: With control bit 3 set, nibble 0000 or 0100 forces F0 and nibble 0001 or 0101 forces F1. Any other progressive nibble leaves alternation in effect. Later frames alternate from the forced parity.
- R7: If the width or height differs from the last interlaced frame, the sequence restarts at the starting field.
- R8: With control bit 0 cleared, progressive frames go through unchanged, including their control packets.
- R9: Writing 1 to control bit 4 requests a restart. That bit reads back 1 until the next interlaced frame takes the restart, and then reads 0.
- R10: The control word lives at address 0, with reset values taken from parameters (default 0x03). Reads from other addresses return 0, and writes to other addresses are ignored.
- R11: A control word written after a frame's control header has been accepted does not affect that frame. It takes effect from the next frame.
- R12: The input is ready on every beat of a dropped row, whatever the output ready. Backpressure stalls only the beats that are kept, and no beat is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DW | Input beat word |
| in_sop | input | 1 | Input first beat of packet |
| in_eop | input | 1 | Input last beat of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DW | Output beat word |
| out_sop | output | 1 | Output first beat of packet |
| out_eop | output | 1 | Output last beat of packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |

## Verification
The main function is driven with runs of frames at a fixed resolution, which separate F0 from F1 line selection and check alternation. Odd heights show whether the halved height follows ceil or floor. Resolution changes and restart writes are placed where plain alternation would give the other parity, and hinted nibbles are chosen against the parity that alternation would pick. Interlaced and disabled-mode frames show that the field sequence is not advanced. Light and heavy downstream backpressure, applied while rows are dropped, separate stalls on kept beats from any stall on discarded ones.

// File: rtl/p2f_pkg.sv
// Shared types for the progressive-to-field converter.
// Assumes packet type in the low nibble of a packet's first word.
package p2f_pkg;
    // Control word; the field order places en at bit 0 up to restart at bit 4.
    typedef struct packed {
        logic restart;
        logic hint_en;
        logic start_f1;
        logic pass_int;
        logic en;
    } p2f_cfg_t;

    typedef enum logic [1:0] {S_IDLE, S_CIN, S_COUT, S_VID} p2f_state_t;
    typedef enum logic [1:0] {M_FIELD, M_PASS, M_DROP} p2f_mode_t;

    localparam logic [3:0] PKT_CTRL = 4'hF;
endpackage

// File: rtl/p2f_regs.sv
// Run-time control word at address 0 with parameter reset values.
// The restart bit stays pending until the datapath reports it was taken.
module p2f_regs
    import p2f_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int AW        = 2,
    parameter bit DEF_EN    = 1'b1,
    parameter bit DEF_PASS  = 1'b1,
    parameter bit DEF_START = 1'b0,
    parameter bit DEF_HINT  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             restart_take,
    output p2f_cfg_t         cfg,
    output logic [REG_W-1:0] reg_rdata
);
    localparam int CFG_W = $bits(p2f_cfg_t);

    logic hit;
    logic unused_wbits;

    assign hit          = reg_wr && (reg_addr == '0);
    assign unused_wbits = ^reg_wdata[REG_W-1:CFG_W];

    // Holds the control fields and the pending restart request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.en       <= DEF_EN;
            cfg.pass_int <= DEF_PASS;
            cfg.start_f1 <= DEF_START;
            cfg.hint_en  <= DEF_HINT;
            cfg.restart  <= 1'b0;
        end else begin
            if (hit) begin
                cfg.en       <= reg_wdata[0];
                cfg.pass_int <= reg_wdata[1];
                cfg.start_f1 <= reg_wdata[2];
                cfg.hint_en  <= reg_wdata[3];
            end
            cfg.restart <= (cfg.restart & ~restart_take) | (hit & reg_wdata[4]);
        end
    end

    // Read mux: only address 0 returns data.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) reg_rdata[CFG_W-1:0] = cfg;
    end
endmodule

// File: rtl/p2f_parity.sv
// Field parity sequencer: picks F0/F1 for each interlaced frame.
// Assumes decide pulses once per progressive frame that is interlaced.
module p2f_parity #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          decide,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [3:0]    nib,
    input  logic          start_f1,
    input  logic          hint_en,
    input  logic          restart_req,
    output logic          field_f1,
    output logic          seq_restart,
    output logic          hinted
);
    logic          nxt_f1, seen, par;
    logic [DW-1:0] pw, ph;
    logic          unused_b2;

    assign unused_b2 = nib[2];

    // Restart, hint and parity selection for the frame being decided.
    always_comb begin
        seq_restart = restart_req | ~seen | (width != pw) | (height != ph);
        hinted      = hint_en & ~nib[3] & ~nib[1];
        if (hinted)           par = nib[0];
        else if (seq_restart) par = start_f1;
        else                  par = nxt_f1;
    end

    // Sequence state: chosen parity, next parity and last resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_f1 <= 1'b0;
            nxt_f1   <= 1'b0;
            seen     <= 1'b0;
            pw       <= '0;
            ph       <= '0;
        end else if (decide) begin
            field_f1 <= par;
            nxt_f1   <= ~par;
            seen     <= 1'b1;
            pw       <= width;
            ph       <= height;
        end
    end
endmodule

// File: rtl/p2f_path.sv
// Stream datapath: absorbs control packets, re-emits or drops them, then
// filters video rows. Assumes 4-beat control packets and height >= 2.
module p2f_path
    import p2f_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  p2f_cfg_t      cfg_live,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop,
    input  logic          field_f1,
    output logic          decide,
    output logic [DW-1:0] w_o,
    output logic [DW-1:0] h_o,
    output logic [3:0]    nib_o,
    output p2f_cfg_t      snap,
    output logic          restart_take
);
    localparam logic [DW-1:0] ONE = DW'(1);
    localparam logic [DW-1:0] TWO = DW'(2);

    p2f_state_t    st;
    p2f_mode_t     mode, nmode;
    logic [1:0]    beat;
    logic [DW-1:0] w_q, h_q, n_q, row, col, half_h, last_row;
    logic          hdr_done, keep, in_acc;

    assign w_o   = w_q;
    assign h_o   = h_q;
    assign nib_o = in_data[3:0];

    // Mode chosen from the nibble beat and the sampled settings.
    always_comb begin
        if (in_data[3]) nmode = snap.pass_int ? M_PASS : M_DROP;
        else            nmode = snap.en ? M_FIELD : M_PASS;
    end

    // Parity request, field height and last kept row.
    always_comb begin
        decide       = (st == S_CIN) && (beat == 2'd2) && in_valid && (nmode == M_FIELD);
        restart_take = decide & snap.restart;
        half_h       = field_f1 ? (h_q >> 1) : ((h_q + ONE) >> 1);
        last_row     = (h_q[0] != field_f1) ? (h_q - ONE) : (h_q - TWO);
        keep         = !hdr_done || (mode == M_PASS) || (row[0] == field_f1);
    end

    // Handshake and output word steering per state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        case (st)
            S_IDLE, S_CIN: in_ready = 1'b1;
            S_COUT: begin
                out_valid = 1'b1;
                out_sop   = (beat == 2'd0);
                out_eop   = (beat == 2'd3);
                case (beat)
                    2'd0: out_data = {{(DW-4){1'b0}}, PKT_CTRL};
                    2'd1: out_data = w_q;
                    2'd2: out_data = (mode == M_FIELD) ? half_h : h_q;
                    default: out_data = (mode == M_FIELD) ?
                                        {{(DW-4){1'b0}}, 3'b100, field_f1} : n_q;
                endcase
            end
            default: begin
                if (mode == M_DROP || !keep) begin
                    in_ready = 1'b1;
                end else begin
                    in_ready  = out_ready;
                    out_valid = in_valid;
                    out_sop   = !hdr_done;
                    out_eop   = (mode == M_PASS) ? in_eop :
                                (hdr_done && row == last_row && col == w_q - ONE);
                end
            end
        endcase
    end

    assign in_acc = in_valid & in_ready;

    // Packet state machine, control capture and row/column counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            mode     <= M_PASS;
            beat     <= 2'd0;
            w_q      <= '0;
            h_q      <= '0;
            n_q      <= '0;
            row      <= '0;
            col      <= '0;
            hdr_done <= 1'b0;
            snap     <= '0;
        end else begin
            case (st)
                S_IDLE: if (in_valid && in_sop) begin
                    if (in_data[3:0] == PKT_CTRL) begin
                        snap <= cfg_live;
                        st   <= S_CIN;
                        beat <= 2'd0;
                    end else if (!in_eop) begin
                        st       <= S_VID;
                        mode     <= M_DROP;
                        hdr_done <= 1'b1;
                    end
                end
                S_CIN: if (in_valid) begin
                    beat <= beat + 2'd1;
                    case (beat)
                        2'd0: w_q <= in_data;
                        2'd1: h_q <= in_data;
                        default: begin
                            n_q      <= in_data;
                            mode     <= nmode;
                            st       <= (nmode == M_DROP) ? S_VID : S_COUT;
                            beat     <= 2'd0;
                            hdr_done <= 1'b0;
                            row      <= '0;
                            col      <= '0;
                        end
                    endcase
                end
                S_COUT: if (out_ready) begin
                    beat <= beat + 2'd1;
                    if (beat == 2'd3) st <= S_VID;
                end
                default: if (in_acc) begin
                    if (!hdr_done) begin
                        hdr_done <= 1'b1;
                    end else if (col == w_q - ONE) begin
                        col <= '0;
                        row <= row + ONE;
                    end else begin
                        col <= col + ONE;
                    end
                    if (in_eop) st <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/p2f_interlacer.sv
// Top of the progressive-to-field converter: control word, parity
// sequencer and stream datapath. Assumes well-formed packets.
module p2f_interlacer
    import p2f_pkg::*;
#(
    parameter int DW        = 16,
    parameter int REG_W     = 32,
    parameter int AW        = 2,
    parameter bit DEF_EN    = 1'b1,
    parameter bit DEF_PASS  = 1'b1,
    parameter bit DEF_START = 1'b0,
    parameter bit DEF_HINT  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic             out_sop,
    output logic             out_eop,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    p2f_cfg_t      cfg_live, snap;
    logic          restart_take, decide, field_f1, seq_restart, hinted;
    logic [DW-1:0] ctl_w, ctl_h;
    logic [3:0]    ctl_nib;

    p2f_regs #(
        .REG_W(REG_W), .AW(AW), .DEF_EN(DEF_EN), .DEF_PASS(DEF_PASS),
        .DEF_START(DEF_START), .DEF_HINT(DEF_HINT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .restart_take(restart_take),
        .cfg(cfg_live), .reg_rdata(reg_rdata)
    );

    p2f_parity #(.DW(DW)) u_par (
        .clk(clk), .rst_n(rst_n), .decide(decide), .width(ctl_w),
        .height(ctl_h), .nib(ctl_nib), .start_f1(snap.start_f1),
        .hint_en(snap.hint_en), .restart_req(snap.restart),
        .field_f1(field_f1), .seq_restart(seq_restart), .hinted(hinted)
    );

    p2f_path #(.DW(DW)) u_path (
        .clk(clk), .rst_n(rst_n), .cfg_live(cfg_live),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .field_f1(field_f1), .decide(decide),
        .w_o(ctl_w), .h_o(ctl_h), .nib_o(ctl_nib), .snap(snap),
        .restart_take(restart_take)
    );
endmodule

// File: rtl/p2f_checker.sv
// Protocol and sequencing properties for p2f_interlacer, bound to the top.
module p2f_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_sop,
    input logic          out_eop,
    input logic          decide,
    input logic          seq_restart,
    input logic          hinted,
    input logic          field_f1,
    input logic          start_f1,
    input logic [3:0]    ctl_nib
);
    // R12: a stalled output beat is held unchanged.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sop) && $stable(out_eop));

    // R12: an output beat offered while input is taken moves in lockstep.
    a_r12_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && in_ready |-> in_valid && out_ready);

    // R12: input is held off only by downstream or by emitting control beats.
    a_r12_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid || !out_ready);

    // R2: without restart or hint the chosen parity flips.
    a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        decide && !seq_restart && !hinted |=> field_f1 != $past(field_f1));

    // R7: a restart without hint lands on the starting field.
    a_r7_restart_start: assert property (@(posedge clk) disable iff (!rst_n)
        decide && seq_restart && !hinted |=> field_f1 == $past(start_f1));

    // R6: a hint forces the parity given by nibble bit 0.
    a_r6_hint_force: assert property (@(posedge clk) disable iff (!rst_n)
        decide && hinted |=> field_f1 == $past(ctl_nib[0]));
endmodule

bind p2f_interlacer p2f_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .decide(decide),
    .seq_restart(seq_restart), .hinted(hinted), .field_f1(field_f1),
    .start_f1(snap.start_f1), .ctl_nib(ctl_nib)
);

// File: tb/tb_p2f_interlacer.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected beats, a monitor compares.
module tb_p2f_interlacer;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, out_sop, out_eop;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    localparam int M_FLD = 0, M_PAS = 1, M_DRP = 2;

    typedef struct packed {logic [15:0] d; logic s; logic e;} beat_t;
    beat_t expq[$];
    string tagq[$];
    int    checks = 0, errors = 0, cyc = 0, bp_sel = 0;
    bit    done = 1'b0;

    p2f_interlacer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_beat(input logic [15:0] d, input bit s, input bit e,
                               input string tag);
        expq.push_back('{d: d, s: s, e: e});
        tagq.push_back(tag);
    endtask

    // Monitor: sets downstream ready, then compares each output transfer.
    initial begin
        forever begin
            @(negedge clk);
            case (bp_sel)
                1: out_ready = (cyc % 3 == 0);
                2: out_ready = cyc[0];
                default: out_ready = 1'b1;
            endcase
            #1;
            if (rst_n && out_valid && out_ready) begin
                beat_t act;
                act = '{d: out_data, s: out_sop, e: out_eop};
                if (expq.size() == 0) begin
                    check(1'b0, "R12", "unexpected output beat", int'(act), 0);
                end else begin
                    beat_t ex;
                    string tg;
                    ex = expq.pop_front();
                    tg = tagq.pop_front();
                    check(act == ex, tg, "output beat {data,sop,eop}", int'(act), int'(ex));
                end
            end
        end
    end

    task automatic put(input logic [15:0] d, input bit s, input bit e, output int stalls);
        stalls = 0;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        forever begin
            #1;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            stalls++;
            @(negedge clk);
        end
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_ctrl(input int w, input int h, input int nib, input int mode,
                             input int par, input string tag);
        int st;
        if (mode == M_FLD) begin
            expect_beat(16'h000F, 1, 0, tag);
            expect_beat(16'(w), 0, 0, tag);
            expect_beat(16'(par ? h / 2 : (h + 1) / 2), 0, 0, tag);
            expect_beat(16'(8 + par), 0, 1, tag);
        end else if (mode == M_PAS) begin
            expect_beat(16'h000F, 1, 0, tag);
            expect_beat(16'(w), 0, 0, tag);
            expect_beat(16'(h), 0, 0, tag);
            expect_beat(16'(nib), 0, 1, tag);
        end
        put(16'h000F, 1, 0, st);
        put(16'(w), 0, 0, st);
        put(16'(h), 0, 0, st);
        put(16'(nib), 0, 1, st);
        idle_in();
    endtask

    task automatic send_video(input int w, input int h, input int mode, input int par,
                              input int fid, input string tag);
        int st, drop_stalls, lk;
        drop_stalls = 0;
        lk = (((h - 1) % 2) == par) ? h - 1 : h - 2;
        if (mode != M_DRP) expect_beat(16'h0000, 1, 0, tag);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                logic [15:0] px;
                px = {4'(fid), 6'(r), 6'(c)};
                if (mode == M_PAS)
                    expect_beat(px, 0, (r == h - 1) && (c == w - 1), tag);
                else if (mode == M_FLD && (r % 2) == par)
                    expect_beat(px, 0, (r == lk) && (c == w - 1), tag);
            end
        end
        put(16'h0000, 1, 0, st);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                put({4'(fid), 6'(r), 6'(c)}, 0, (r == h - 1) && (c == w - 1), st);
                if (mode != M_PAS && (mode == M_DRP || (r % 2) != par))
                    drop_stalls += st;
            end
        end
        idle_in();
        if (mode != M_PAS)
            check(drop_stalls == 0, "R12", "stall cycles on discarded beats", drop_stalls, 0);
    endtask

    task automatic frame(input int w, input int h, input int nib, input int mode,
                         input int par, input int fid, input string tag);
        send_ctrl(w, h, nib, mode, par, tag);
        send_video(w, h, mode, par, fid, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired, queue depth %0d expected 0", expq.size());
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        rd(2'd0, v);
        check(v == 32'h03, "R10", "control word after reset", int'(v), 32'h03);

        // Alternation at a fixed resolution, first field from the start setting.
        frame(3, 4, 2, M_FLD, 0, 1, "R4");
        frame(3, 4, 2, M_FLD, 1, 2, "R2");
        frame(3, 4, 2, M_FLD, 0, 3, "R1");
        // Resolution change restarts at F0 where alternation would give F1.
        frame(3, 5, 2, M_FLD, 0, 4, "R7");
        frame(3, 5, 2, M_FLD, 1, 5, "R3");

        // Start at F1 and request a restart.
        wr(2'd0, 32'h17);
        rd(2'd0, v);
        check(v[4] == 1'b1, "R9", "restart bit pending", int'(v[4]), 1);
        frame(3, 5, 2, M_FLD, 1, 6, "R9");
        rd(2'd0, v);
        check(v == 32'h07, "R9", "restart bit cleared after use", int'(v), 32'h07);
        frame(3, 5, 2, M_FLD, 0, 7, "R2");

        // Hint override.
        wr(2'd0, 32'h0F);
        frame(3, 5, 4, M_FLD, 0, 8, "R6");
        frame(3, 5, 2, M_FLD, 1, 9, "R6");
        frame(3, 5, 5, M_FLD, 1, 10, "R6");
        frame(3, 5, 3, M_FLD, 0, 11, "R6");

        // Interlaced input forwarded, then sequence continues untouched.
        frame(3, 5, 8, M_PAS, 0, 12, "R5");
        frame(3, 5, 2, M_FLD, 1, 13, "R2");

        // Interlaced input discarded; stray address ignored.
        wr(2'd0, 32'h0D);
        wr(2'd1, 32'h00);
        rd(2'd1, v);
        check(v == 32'h0, "R10", "read of unused address", int'(v), 0);
        rd(2'd0, v);
        check(v == 32'h0D, "R10", "control word after stray write", int'(v), 32'h0D);
        frame(3, 5, 9, M_DRP, 0, 14, "R5");
        frame(3, 5, 2, M_FLD, 0, 15, "R5");

        // Disable written after the control header: this frame still a field.
        send_ctrl(3, 5, 2, M_FLD, 1, "R11");
        wr(2'd0, 32'h0C);
        send_video(3, 5, M_FLD, 1, 1, "R11");
        frame(3, 5, 2, M_PAS, 0, 2, "R8");
        frame(4, 2, 6, M_PAS, 0, 3, "R8");

        // Backpressure on kept beats.
        wr(2'd0, 32'h0D);
        bp_sel = 1;
        frame(3, 5, 2, M_FLD, 0, 4, "R12");
        frame(5, 6, 2, M_FLD, 1, 5, "R7");
        bp_sel = 2;
        frame(5, 6, 0, M_FLD, 0, 6, "R6");
        frame(5, 6, 2, M_FLD, 1, 7, "R12");

        wait (expq.size() == 0);
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R12", "beats left unmatched", expq.size(), 0);
        finish_run();
    end
endmodule